// File: doc/BRIEF.md
# Sixteen-Operand Carry-Save Summation Tree

This block is the adder core behind a parallel FIR tap bank. Each clock it can take sixteen signed operands per lane and return their exact sum. The sum keeps full precision, so nothing is truncated. By default there are two lanes, one for the even stream and one for the odd stream. Each lane has its own datapath, and the two lanes share one handshake.

The operands in a lane are first sign-extended to the width of the result. Three levels of 4:2 compressor rows then cut them down from sixteen vectors to eight, then four, then a final sum/carry pair. A Kogge-Stone parallel-prefix adder resolves that last pair. There is a register bank in front of each compressor level and one in front of the final adder, which makes four register stages in all. The result leaves the prefix adder directly, with no further register.

Data enters and leaves on valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. The pipeline advances as one unit. It can advance whenever its last stage is empty or the consumer is ready. When the consumer holds `out_ready` low while a result is waiting, the whole pipeline freezes, the held result stays on the outputs, and `in_ready` goes low. Empty cycles (bubbles) on the input side pass through without producing output.

Top module: `csa_sum_tree`

## Requirements
- R1: For every accepted beat, each lane's output equals the signed sum of that lane's sixteen operands, as a two's-complement value of IN_W+4 bits. Operand j of lane l sits at `in_ops[(l*16+j)*IN_W +: IN_W]`. Lane l's result sits at `out_sum[l*(IN_W+4) +: IN_W+4]`.
- R2: The extreme inputs never wrap. With IN_W=12, sixteen operands all equal to -2048 give -32768, and sixteen operands all equal to 2047 give 32752.
- R3: Lanes are independent. A lane's result depends only on that lane's operands.
- R4: If `out_ready` stays high, a beat accepted at one rising edge shows up with `out_valid` high after the fourth rising edge from then. The block accepts one beat per clock.
- R5: While `out_valid` is high and `out_ready` is low, `out_sum` and `out_valid` keep their values into the next cycle and `in_ready` is low.
- R6: `in_ready` is high in every cycle where `out_valid` is low.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: Results come out in acceptance order. Each accepted beat produces exactly one result, and cycles with `in_valid` low produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the stage valid flags |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_ops | input | LANES*16*IN_W | Sixteen signed operands per lane, packed lane-major |
| out_valid | output | 1 | Result present on `out_sum` |
| out_ready | input | 1 | Consumer accepts the result this cycle |
| out_sum | output | LANES*(IN_W+4) | Full-precision signed sum per lane |

## Verification
The assertions run on every cycle. They check that a stalled result stays frozen and that `in_ready` drops during a stall. They check the four-edge latency whenever ready has been held high, that every lane result lies inside the range sixteen operands can reach, and that reset empties the output. Arithmetic correctness needs the bench scenarios. These are a sweep of all operand values with every operand in a lane set equal, the two extremes, lanes driven with unrelated data, and long random runs with bubbles and back-pressure. A scoreboard in the bench checks that results keep their order and that none is lost or duplicated.

// File: rtl/sumtree_pkg.sv
package sumtree_pkg;
  localparam int OPS_PER_LANE = 16;
  localparam int GROW_BITS    = $clog2(OPS_PER_LANE);

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/c42_cell.sv
module c42_cell
  import sumtree_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic ci,
  output logic s,
  output logic cy,
  output logic co
);
  logic t;
  // co is formed from a, b, c only, so it never waits on ci
  assign t  = a ^ b ^ c;
  assign co = maj3(a, b, c);
  assign s  = t ^ d ^ ci;
  assign cy = maj3(t, d, ci);
endmodule

// File: rtl/c42_row.sv
module c42_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] sum_v,
  output logic [W-1:0] cry_v
);
  logic [W:0]   chain;
  logic [W-1:0] cyb;
  logic         unused_msb;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    c42_cell u_cell (
      .a (a[i]),
      .b (b[i]),
      .c (c[i]),
      .d (d[i]),
      .ci(chain[i]),
      .s (sum_v[i]),
      .cy(cyb[i]),
      .co(chain[i+1])
    );
  end

  // weight-2 outputs move up one column; bits past the top are modulo-discarded
  assign cry_v      = {cyb[W-2:0], 1'b0};
  assign unused_msb = chain[W] ^ cyb[W-1];
endmodule

// File: rtl/ks_adder.sv
module ks_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int LV = $clog2(W);

  logic [W-1:0] g [LV+1];
  logic [W-1:0] p [LV+1];
  logic         unused_tail;

  assign g[0] = x & y;
  assign p[0] = x ^ y;

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_col
      if (i >= D) begin : g_merge
        assign g[k+1][i] = g[k][i] | (p[k][i] & g[k][i-D]);
        assign p[k+1][i] = p[k][i] & p[k][i-D];
      end else begin : g_pass
        assign g[k+1][i] = g[k][i];
        assign p[k+1][i] = p[k][i];
      end
    end
  end

  assign s           = p[0] ^ {g[LV][W-2:0], 1'b0};
  assign unused_tail = g[LV][W-1] ^ (^p[LV]);
endmodule

// File: rtl/csa_sum_tree.sv
module csa_sum_tree
  import sumtree_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int LANES = 2,
  localparam int NOPS  = OPS_PER_LANE,
  localparam int SUM_W = IN_W + GROW_BITS,
  localparam int XW    = SUM_W - IN_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [LANES*NOPS*IN_W-1:0]  in_ops,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LANES*SUM_W-1:0]      out_sum
);
  localparam int NSTG = 4;

  logic [NSTG-1:0] vld;
  logic            adv;

  assign out_valid = vld[NSTG-1];
  assign adv       = ~vld[NSTG-1] | out_ready;
  assign in_ready  = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[NSTG-2:0], in_valid};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SUM_W-1:0] st0 [NOPS];
    logic [SUM_W-1:0] lv1 [NOPS/2];
    logic [SUM_W-1:0] st1 [NOPS/2];
    logic [SUM_W-1:0] lv2 [NOPS/4];
    logic [SUM_W-1:0] st2 [NOPS/4];
    logic [SUM_W-1:0] lv3 [NOPS/8];
    logic [SUM_W-1:0] st3 [NOPS/8];

    // stage 0: sign-extend and capture
    always_ff @(posedge clk) begin
      if (adv) begin
        for (int i = 0; i < NOPS; i++) begin
          st0[i] <= {{XW{in_ops[(l*NOPS+i)*IN_W+IN_W-1]}},
                     in_ops[(l*NOPS+i)*IN_W +: IN_W]};
        end
      end
    end

    for (genvar q = 0; q < NOPS/4; q++) begin : g_l1
      c42_row #(.W(SUM_W)) u_row (
        .a(st0[4*q]), .b(st0[4*q+1]), .c(st0[4*q+2]), .d(st0[4*q+3]),
        .sum_v(lv1[2*q]), .cry_v(lv1[2*q+1])
      );
    end

    always_ff @(posedge clk) begin
      if (adv) for (int i = 0; i < NOPS/2; i++) st1[i] <= lv1[i];
    end

    for (genvar q = 0; q < NOPS/8; q++) begin : g_l2
      c42_row #(.W(SUM_W)) u_row (
        .a(st1[4*q]), .b(st1[4*q+1]), .c(st1[4*q+2]), .d(st1[4*q+3]),
        .sum_v(lv2[2*q]), .cry_v(lv2[2*q+1])
      );
    end

    always_ff @(posedge clk) begin
      if (adv) for (int i = 0; i < NOPS/4; i++) st2[i] <= lv2[i];
    end

    c42_row #(.W(SUM_W)) u_l3 (
      .a(st2[0]), .b(st2[1]), .c(st2[2]), .d(st2[3]),
      .sum_v(lv3[0]), .cry_v(lv3[1])
    );

    always_ff @(posedge clk) begin
      if (adv) for (int i = 0; i < NOPS/8; i++) st3[i] <= lv3[i];
    end

    ks_adder #(.W(SUM_W)) u_cpa (
      .x(st3[0]),
      .y(st3[1]),
      .s(out_sum[l*SUM_W +: SUM_W])
    );
  end
endmodule

// File: rtl/csa_sum_tree_chk.sv
module csa_sum_tree_chk
  import sumtree_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int LANES = 2,
  localparam int SUM_W = IN_W + GROW_BITS
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*SUM_W-1:0] out_sum
);
  localparam int LO = -(OPS_PER_LANE * (1 << (IN_W - 1)));
  localparam int HI = OPS_PER_LANE * ((1 << (IN_W - 1)) - 1);

  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  // R5: a stalled result is frozen and nothing new enters
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));

  p_stall_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4: four-edge latency with ready held high
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst == 3'd4) && $past(in_valid && in_ready, 4) &&
     $past(out_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1))
    |-> out_valid);

  // R7: output empty right after reset
  p_reset_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd0) |-> (!out_valid && in_ready));

  // R2: every lane result lies within reachable range
  for (genvar l = 0; l < LANES; l++) begin : g_rng
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_sum[l*SUM_W +: SUM_W]) >= LO &&
                     $signed(out_sum[l*SUM_W +: SUM_W]) <= HI));
  end
endmodule

bind csa_sum_tree csa_sum_tree_chk #(.IN_W(IN_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_sum(out_sum)
);

// File: tb/tb_csa_sum_tree.sv
module tb_csa_sum_tree;
  localparam int IN_W  = 12;
  localparam int LANES = 2;
  localparam int NOPS  = 16;
  localparam int SUM_W = IN_W + 4;
  localparam int OW    = LANES*NOPS*IN_W;
  localparam int RW    = LANES*SUM_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [OW-1:0] in_ops = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [RW-1:0] out_sum;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int accs = 0;
  int outs = 0;
  bit lat_mode = 1'b0;
  bit prev_stall = 1'b0;
  logic [RW-1:0] prev_sum = '0;
  string cur_tag = "R1";
  logic [RW-1:0] exp_q[$];
  int            acc_q[$];

  always #5 clk = ~clk;

  csa_sum_tree #(.IN_W(IN_W), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ops(in_ops), .out_valid(out_valid), .out_ready(out_ready),
    .out_sum(out_sum)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic logic [RW-1:0] ref_sum(input logic [OW-1:0] v);
    logic [RW-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      int s = 0;
      for (int j = 0; j < NOPS; j++) s += int'($signed(v[(l*NOPS+j)*IN_W +: IN_W]));
      r[l*SUM_W +: SUM_W] = SUM_W'(s);
    end
    return r;
  endfunction

  function automatic logic [OW-1:0] fill(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b);
    logic [OW-1:0] v;
    for (int j = 0; j < NOPS; j++) begin
      v[j*IN_W +: IN_W]        = a;
      v[(NOPS+j)*IN_W +: IN_W] = b;
    end
    return v;
  endfunction

  function automatic logic [OW-1:0] rnd_ops();
    logic [OW-1:0] v;
    for (int k = 0; k < LANES*NOPS; k++) v[k*IN_W +: IN_W] = IN_W'($urandom());
    return v;
  endfunction

  task automatic step(input bit v, input logic [OW-1:0] ops, input bit rdy);
    logic [RW-1:0] e;
    int a;
    in_valid = v; in_ops = ops; out_ready = rdy;
    #1;
    cyc++;
    if (prev_stall)
      chk(out_valid && out_sum == prev_sum, "R5 held result", 64'(out_sum), 64'(prev_sum));
    if (!out_valid) chk(in_ready, "R6 ready when empty", 64'(in_ready), 64'd1);
    if (out_valid && !out_ready) chk(!in_ready, "R5 no accept in stall", 64'(in_ready), 64'd0);
    if (out_valid && out_ready) begin
      outs++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected result", 64'(out_sum), 64'd0);
      end else begin
        e = exp_q.pop_front();
        a = acc_q.pop_front();
        for (int l = 0; l < LANES; l++)
          chk(out_sum[l*SUM_W +: SUM_W] == e[l*SUM_W +: SUM_W], cur_tag,
              64'(out_sum[l*SUM_W +: SUM_W]), 64'(e[l*SUM_W +: SUM_W]));
        if (lat_mode) chk(cyc - a == 4, "R4 latency", 64'(cyc - a), 64'd4);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_sum   = out_sum;
    if (v && in_ready) begin
      exp_q.push_back(ref_sum(ops));
      acc_q.push_back(cyc);
      accs++;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b1);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk(!out_valid, "R7 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready, "R7 in_ready after reset", 64'(in_ready), 64'd1);

    // R4: single beat, ready held high
    lat_mode = 1'b1; cur_tag = "R4 single beat";
    step(1'b1, rnd_ops(), 1'b1);
    drain();

    // R1: sweep every operand value, back to back
    cur_tag = "R1 value sweep";
    for (int v = 0; v < (1 << IN_W); v++)
      step(1'b1, fill(IN_W'(v), ~IN_W'(v)), 1'b1);
    drain();

    // R2: extremes in both lanes and mixed
    cur_tag = "R2 extremes";
    step(1'b1, fill({1'b1, {(IN_W-1){1'b0}}}, {1'b1, {(IN_W-1){1'b0}}}), 1'b1);
    step(1'b1, fill({1'b0, {(IN_W-1){1'b1}}}, {1'b0, {(IN_W-1){1'b1}}}), 1'b1);
    step(1'b1, fill({1'b1, {(IN_W-1){1'b0}}}, {1'b0, {(IN_W-1){1'b1}}}), 1'b1);
    drain();
    chk(ref_sum(fill({1'b1, {(IN_W-1){1'b0}}}, 0))[SUM_W-1:0] == 16'h8000,
        "R2 min reference", 64'(ref_sum(fill({1'b1, {(IN_W-1){1'b0}}}, 0))[SUM_W-1:0]), 64'h8000);

    // R3: lane 0 random, lane 1 fixed alternating extremes
    cur_tag = "R3 lane independence";
    for (int k = 0; k < 300; k++) begin
      logic [OW-1:0] o;
      o = rnd_ops();
      for (int j = 0; j < NOPS; j++)
        o[(NOPS+j)*IN_W +: IN_W] = j[0] ? {1'b1, {(IN_W-1){1'b0}}} : {1'b0, {(IN_W-1){1'b1}}};
      step(1'b1, o, 1'b1);
    end
    drain();

    // R5/R8: random bubbles and back-pressure
    lat_mode = 1'b0; cur_tag = "R8 ordered random";
    for (int k = 0; k < 4000; k++)
      step(($urandom() % 10) < 7, rnd_ops(), ($urandom() % 10) < 6);
    drain();
    chk(exp_q.size() == 0, "R8 nothing left", 64'(exp_q.size()), 64'd0);
    chk(accs == outs, "R8 one result per beat", 64'(outs), 64'(accs));

    report();
    $finish;
  end
endmodule